// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps enable, pending and active state for a bank of interrupt lines. It also keeps a small priority field for each line, and from this state it picks the one line that should be serviced next. The state bits are grouped into 32-bit words. Each enable word and each pending word can be reached through two aliases. One alias sets bits when a 1 is written, the other clears bits when a 1 is written, and both read back the same stored state. An interrupt input that goes high always latches the line as pending. Only a line that is both pending and enabled can take part in arbitration.

A core-side agent sees `actReq` and `actId` and accepts the offered line by pulsing `actTake`. When it accepts, the line's pending bit drops and its active bit rises in the same clock. When the handler finishes, a one-cycle `doneValid` pulse with `doneId` clears that active bit. Register writes commit on the rising clock edge. Register reads are combinational from the current state.

Top module: `irqEnablePendBank`

## Requirements
- R1: Line n lives in word n/32, bit n%32. The register address is {region[2:0], index}. The region codes are 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 active and 5 priority. The index is the word number. The index width is 4 with the default parameters.
- R2: Writing 1 to a set-enable bit enables that line, and writing 0 leaves it unchanged. Reading the set-enable word returns the enable state, with 1 meaning enabled.
- R3: Writing 1 to a clear-enable bit disables that line, and writing 0 leaves it unchanged. Reading the clear-enable word returns the same enable state as the set-enable word.
- R4: Writing 1 to a set-pending bit makes the line pending, and writing 1 to a clear-pending bit clears it. Writing 0 to either has no effect. Both aliases read back the pending state.
- R5: An `irqIn` bit that is high at a clock edge makes that line pending, whether or not the line is enabled.
- R6: `actReq` is high only when some line is both pending and enabled. A line that is pending but disabled is never offered.
- R7: Among the candidate lines, the one with the lowest priority value is offered on `actId`. When values tie, the lower line number wins.
- R8: `actTake` sampled with `actReq` high clears the offered line's pending bit and sets its active bit at the same edge.
- R9: Reading the active word returns the active bits. Writes to the active word are ignored.
- R10: If `irqIn` and a clear-pending write reach the same line in the same cycle, the line stays pending.
- R11: `doneValid` clears the active bit of line `doneId`.
- R12: Each priority word holds 8 lines. Line n sits at bits [4*(n%8)+2 : 4*(n%8)] of priority word n/8. The top bit of each 4-bit slot reads as 0.
- R13: After reset, all enable, pending, active and priority state reads as 0 and `actReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 7 | Region code and word index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| irqIn | input | 128 | Interrupt inputs, one per line |
| actTake | input | 1 | Accepts the offered line |
| actReq | output | 1 | A candidate line is offered |
| actId | output | 7 | Number of the offered line |
| doneValid | input | 1 | Completion pulse |
| doneId | input | 7 | Line that completed |

## Verification
The bench builds the block with its defaults: 128 lines and 3-bit priorities. This gives four bitmap words and sixteen priority words. With these values the bench can reach the top line, 127, in word 3, as a pending line that is disabled. It can also set up priority ties and reorderings among neighbouring lines that share one priority word. It tests an input that arrives in the same cycle as a clear write, and an acceptance that hands arbitration on to the next candidate.

// File: rtl/irqBankPkg.sv
package irqBankPkg;
  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    RG_SET_EN   = 3'd0,
    RG_CLR_EN   = 3'd1,
    RG_SET_PEND = 3'd2,
    RG_CLR_PEND = 3'd3,
    RG_ACTIVE   = 3'd4,
    RG_PRIO     = 3'd5
  } regionE;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setPend;
    logic clrPend;
    logic prioWr;
  } strobeT;
endpackage

// File: rtl/irqBankCtrl.sv
module irqBankCtrl
  import irqBankPkg::*;
(
  input  logic       regWr,
  input  logic [2:0] region,
  output strobeT     strb
);
  // Active-word writes produce no strobe, so they are dropped (R9).
  always_comb begin
    strb = '0;
    if (regWr) begin
      case (regionE'(region))
        RG_SET_EN:   strb.setEn   = 1'b1;
        RG_CLR_EN:   strb.clrEn   = 1'b1;
        RG_SET_PEND: strb.setPend = 1'b1;
        RG_CLR_PEND: strb.clrPend = 1'b1;
        RG_PRIO:     strb.prioWr  = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/irqBankDatapath.sv
module irqBankDatapath
  import irqBankPkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int PRIO_W    = 3,
  localparam int NUM_WORDS = NUM_LINES / WORD_W,
  localparam int PER_PW    = WORD_W / NIB_W,
  localparam int NUM_PW    = NUM_LINES / PER_PW,
  localparam int IDX_W     = $clog2(NUM_PW),
  localparam int WI_W      = $clog2(NUM_WORDS),
  localparam int ID_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strb,
  input  logic [2:0]           region,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [WORD_W-1:0]    wrData,
  output logic [WORD_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 actTake,
  output logic                 actReq,
  output logic [ID_W-1:0]      actId,
  input  logic                 doneValid,
  input  logic [ID_W-1:0]      doneId,
  output logic [NUM_LINES-1:0] enBits,
  output logic [NUM_LINES-1:0] pendBits,
  output logic [NUM_LINES-1:0] actBits
);
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
  logic [NUM_PW-1:0][WORD_W-1:0]    prioW;
  logic [NUM_WORDS-1:0][WORD_W-1:0] enW, pendW, actW;
  logic takeNow;

  assign takeNow = actTake && actReq;

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    localparam int W  = i / WORD_W;
    localparam int B  = i % WORD_W;
    localparam int PW = i / PER_PW;
    localparam int PN = i % PER_PW;
    logic enR, pendR, actR;
    logic [PRIO_W-1:0] prioR;
    logic hitW, hitP, takeMe;

    assign hitW   = (wrIdx == IDX_W'(W)) && wrData[B];
    assign hitP   = (wrIdx == IDX_W'(PW));
    assign takeMe = takeNow && (actId == ID_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= 1'b0;
        pendR <= 1'b0;
        actR  <= 1'b0;
        prioR <= '0;
      end else begin
        if (strb.setEn && hitW)      enR <= 1'b1;
        else if (strb.clrEn && hitW) enR <= 1'b0;
        // input beats clear and acceptance
        if (irqIn[i] || (strb.setPend && hitW))       pendR <= 1'b1;
        else if ((strb.clrPend && hitW) || takeMe)    pendR <= 1'b0;
        if (takeMe)                                    actR <= 1'b1;
        else if (doneValid && doneId == ID_W'(i))      actR <= 1'b0;
        if (strb.prioWr && hitP) prioR <= wrData[PN*NIB_W +: PRIO_W];
      end
    end

    assign enBits[i]   = enR;
    assign pendBits[i] = pendR;
    assign actBits[i]  = actR;
    assign prio[i]     = prioR;
    assign prioW[PW][PN*NIB_W +: NIB_W] = NIB_W'(prioR);
  end

  assign enW   = enBits;
  assign pendW = pendBits;
  assign actW  = actBits;

  // Arbiter: strict less-than keeps the lower line on ties.
  always_comb begin
    logic [PRIO_W-1:0] bestP;
    actReq = 1'b0;
    actId  = '0;
    bestP  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pendBits[i] && enBits[i] && (!actReq || prio[i] < bestP)) begin
        actReq = 1'b1;
        actId  = ID_W'(i);
        bestP  = prio[i];
      end
    end
  end

  always_comb begin
    logic inWords;
    inWords = (int'(wrIdx) < NUM_WORDS);
    rdData  = '0;
    case (regionE'(region))
      RG_SET_EN, RG_CLR_EN:     if (inWords) rdData = enW[wrIdx[WI_W-1:0]];
      RG_SET_PEND, RG_CLR_PEND: if (inWords) rdData = pendW[wrIdx[WI_W-1:0]];
      RG_ACTIVE:                if (inWords) rdData = actW[wrIdx[WI_W-1:0]];
      RG_PRIO:                  rdData = prioW[wrIdx];
      default:                  rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqEnablePendBank.sv
module irqEnablePendBank
  import irqBankPkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int PRIO_W    = 3,
  localparam int IDX_W  = $clog2(NUM_LINES / (WORD_W / NIB_W)),
  localparam int ADDR_W = 3 + IDX_W,
  localparam int ID_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  output logic [WORD_W-1:0]    regRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 actTake,
  output logic                 actReq,
  output logic [ID_W-1:0]      actId,
  input  logic                 doneValid,
  input  logic [ID_W-1:0]      doneId
);
  strobeT strb;
  logic [NUM_LINES-1:0] enBits, pendBits, actBits;

  irqBankCtrl uCtrl (
    .regWr  (regWr),
    .region (regAddr[ADDR_W-1 -: 3]),
    .strb   (strb)
  );

  irqBankDatapath #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .region    (regAddr[ADDR_W-1 -: 3]),
    .wrIdx     (regAddr[IDX_W-1:0]),
    .wrData    (regWdata),
    .rdData    (regRdata),
    .irqIn     (irqIn),
    .actTake   (actTake),
    .actReq    (actReq),
    .actId     (actId),
    .doneValid (doneValid),
    .doneId    (doneId),
    .enBits    (enBits),
    .pendBits  (pendBits),
    .actBits   (actBits)
  );
endmodule

// File: rtl/irqBankChecker.sv
module irqBankChecker #(
  parameter int NUM_LINES = 128,
  localparam int ID_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWr,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 actTake,
  input logic                 actReq,
  input logic [ID_W-1:0]      actId,
  input logic                 doneValid,
  input logic [ID_W-1:0]      doneId,
  input logic [NUM_LINES-1:0] enBits,
  input logic [NUM_LINES-1:0] pendBits,
  input logic [NUM_LINES-1:0] actBits
);
  a_r6_offer_enabled_pending: assert property (@(posedge clk) disable iff (!rstN)
    actReq |-> (enBits[actId] && pendBits[actId]));

  a_r6_no_offer_without_candidate: assert property (@(posedge clk) disable iff (!rstN)
    ((enBits & pendBits) == '0) |-> !actReq);

  a_r8_take_sets_active: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && actTake) |=> actBits[$past(actId)]);

  a_r5_input_latches: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn != '0) |=> ((pendBits & $past(irqIn)) == $past(irqIn)));

  a_r11_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !(actReq && actTake && actId == doneId)) |=> !actBits[$past(doneId)]);

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> $stable(enBits));
endmodule

bind irqEnablePendBank irqBankChecker #(.NUM_LINES(NUM_LINES)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .irqIn(irqIn), .actTake(actTake),
  .actReq(actReq), .actId(actId), .doneValid(doneValid), .doneId(doneId),
  .enBits(enBits), .pendBits(pendBits), .actBits(actBits)
);

// File: tb/tb_irqEnablePendBank.sv
module tb_irqEnablePendBank;
  localparam int NL = 128;
  localparam int IDX_W = 4;
  localparam int ID_W = 7;
  localparam logic [2:0] SEN = 3'd0, CEN = 3'd1, SPD = 3'd2, CPD = 3'd3, ACT = 3'd4, PRI = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [IDX_W+2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NL-1:0] irqIn = '0;
  logic actTake = 1'b0;
  logic actReq;
  logic [ID_W-1:0] actId;
  logic doneValid = 1'b0;
  logic [ID_W-1:0] doneId = '0;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  irqEnablePendBank dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqIn(irqIn), .actTake(actTake), .actReq(actReq),
    .actId(actId), .doneValid(doneValid), .doneId(doneId)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] rg, input int idx, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = {rg, IDX_W'(idx)}; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic expectWord(input logic [2:0] rg, input int idx, input logic [31:0] exp, input string tag);
    regAddr = {rg, IDX_W'(idx)};
    #1;
    check(regRdata === exp, tag, regRdata, exp);
  endtask

  task automatic expectOffer(input bit req, input int id, input string tag);
    #1;
    check(actReq === req && (!req || actId === ID_W'(id)), tag, {actReq, 24'd0, actId}, {req, 24'd0, ID_W'(id)});
  endtask

  task automatic testReset();
    for (int w = 0; w < 4; w++) begin
      expectWord(SEN, w, 32'h0, "R13 enable reset");
      expectWord(SPD, w, 32'h0, "R13 pending reset");
      expectWord(ACT, w, 32'h0, "R13 active reset");
    end
    expectWord(PRI, 15, 32'h0, "R13 priority reset");
    expectOffer(1'b0, 0, "R13 no offer at reset");
  endtask

  task automatic testEnable();
    busWrite(SEN, 1, 32'h0000_00F0);
    expectWord(SEN, 1, 32'h0000_00F0, "R2 set-enable readback");
    expectWord(CEN, 1, 32'h0000_00F0, "R3 clear alias reads enable");
    busWrite(SEN, 1, 32'h0);
    expectWord(SEN, 1, 32'h0000_00F0, "R2 zero write no effect");
    busWrite(CEN, 1, 32'h0000_0010);
    expectWord(SEN, 1, 32'h0000_00E0, "R3 clear-enable clears line 36");
    busWrite(CEN, 1, 32'h0);
    expectWord(CEN, 1, 32'h0000_00E0, "R3 zero write no effect");
    expectWord(SEN, 0, 32'h0, "R1 word 0 untouched");
  endtask

  task automatic testDisabledInput();
    @(negedge clk); irqIn[127] = 1'b1;
    @(negedge clk); irqIn = '0;
    expectWord(SPD, 3, 32'h8000_0000, "R5 disabled line 127 pending");
    expectOffer(1'b0, 0, "R6 disabled pending not offered");
  endtask

  task automatic testPendAliases();
    busWrite(SPD, 1, 32'h0000_0020);
    expectWord(CPD, 1, 32'h0000_0020, "R4 set-pending line 37");
    expectOffer(1'b1, 37, "R6 enabled pending offered");
    busWrite(CPD, 1, 32'h0);
    expectWord(SPD, 1, 32'h0000_0020, "R4 zero clear no effect");
    busWrite(CPD, 1, 32'h0000_0020);
    expectWord(SPD, 1, 32'h0, "R4 clear-pending");
    expectOffer(1'b0, 0, "R6 no candidate left");
  endtask

  task automatic testPriority();
    busWrite(PRI, 4, (32'd1 << 20) | (32'd2 << 24) | (32'd1 << 28));
    expectWord(PRI, 4, 32'h1210_0000, "R12 priority readback");
    busWrite(SPD, 1, 32'h0000_00E0);
    expectOffer(1'b1, 37, "R7 tie goes to lower line");
    busWrite(PRI, 4, (32'd3 << 20) | (32'd2 << 24) | (32'd1 << 28));
    expectOffer(1'b1, 39, "R7 lowest value wins");
    busWrite(PRI, 0, 32'hFFFF_FFFF);
    expectWord(PRI, 0, 32'h7777_7777, "R12 slot top bit reads 0");
  endtask

  task automatic testTakeDone();
    @(negedge clk); actTake = 1'b1;
    @(negedge clk); actTake = 1'b0;
    expectWord(ACT, 1, 32'h0000_0080, "R8 active set on take");
    expectWord(SPD, 1, 32'h0000_0060, "R8 pending cleared on take");
    expectOffer(1'b1, 38, "R7 next candidate offered");
    busWrite(ACT, 1, 32'hFFFF_FFFF);
    expectWord(ACT, 1, 32'h0000_0080, "R9 active write ignored");
    @(negedge clk); doneValid = 1'b1; doneId = 7'd39;
    @(negedge clk); doneValid = 1'b0;
    expectWord(ACT, 1, 32'h0, "R11 done clears active");
  endtask

  task automatic testRace();
    @(negedge clk);
    irqIn[5] = 1'b1; regWr = 1'b1; regAddr = {CPD, IDX_W'(0)}; regWdata = 32'h20;
    @(negedge clk);
    irqIn = '0; regWr = 1'b0;
    expectWord(SPD, 0, 32'h0000_0020, "R10 input beats clear");
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testEnable();
    testDisabledInput();
    testPendAliases();
    testPriority();
    testTakeDone();
    testRace();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule